// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. It accepts the missing virtual page number together with the physical base of the root directory. It fetches the directory entry that covers the upper part of the page number. From that entry it forms the base of the second-level table and fetches the final entry selected by the lower part of the page number. A usable final entry is handed to the translation cache as a refill. If either level is unusable, the walk ends with a fault that records which level failed.

Memory is reached through a request channel with a valid/ready handshake and a response channel that carries a data strobe. The number of cycles between request and grant, and between grant and response, may be anything. Only one walk is in flight at a time. A new miss is taken only when the walker is idle.

Every entry is one word. The frame number sits in the top bits, just above the page-offset width. The low five bits are flags. Bit 0 means present/valid, bit 1 read, bit 2 write, bit 3 execute and bit 4 user access. A directory entry uses bit 0 and its frame field only.

Top module: `pt_walk_engine`

## Requirements
- R1: During and right after reset, `miss_ready` is 1 and `mem_req_valid`, `refill_valid` and `fault_valid` are 0.
- R2: The first request of a walk reads address `root_base + 4*vpn[19:10]`, using the root value captured when the miss was accepted.
- R3: The second request is issued only after the directory response. Its address is `{dir_entry[31:12], 12'h000} + 4*vpn[9:0]`.
- R4: A directory entry with bit 0 clear ends the walk after exactly one read, with `fault_valid` high, `fault_level` 0 and `fault_vpn` equal to the missing page.
- R5: A final entry with bit 0 clear gives `fault_valid` with `fault_level` 1 after two reads, and no refill.
- R6: A final entry with bit 0 set gives `refill_valid`. `refill_pfn` is `entry[31:12]`. `refill_perm` is `entry[4:1]` (bit 0 read, bit 1 write, bit 2 execute, bit 3 user). `refill_vpn` is the missing page.
- R7: A request stays asserted with a constant address until granted. Any grant delay and any response delay give the same result.
- R8: A miss is accepted only while `miss_ready` is 1. `miss_ready` stays 0 for the whole walk, and `miss_vpn`/`root_base` changes made during a walk have no effect on it.
- R9: `refill_valid` and `fault_valid` are never high together. Each lasts one cycle, and `miss_ready` returns to 1 in the following cycle.
- R10: A response strobe that arrives while no read is outstanding is ignored. It causes no output, no request and no change to the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker idle; miss taken when both high |
| miss_vpn | input | 20 | Missing virtual page number |
| root_base | input | 32 | Physical base of the root directory |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Returned entry word |
| refill_valid | output | 1 | One-cycle refill pulse |
| refill_vpn | output | 20 | Page being refilled |
| refill_pfn | output | 20 | Physical frame number |
| refill_perm | output | 4 | {user, execute, write, read} |
| fault_valid | output | 1 | One-cycle page fault pulse |
| fault_vpn | output | 20 | Faulting page |
| fault_level | output | 1 | 0 = directory level, 1 = final level |

## Verification
A corrupted state register shows up at the memory port within a cycle or two. It may send a request while idle, send no second request, or send a third read. It may also leave `miss_ready` low for good, which the per-walk timeout catches. A wrong captured base or index changes the address of the very next request. A wrong latched entry or fault level shows on the single refill or fault pulse that ends the same walk. The sweep varies grant and response delays, so a state that drops a strobe or moves on before a strobe is exposed as a wrong read count or a hang.

// File: rtl/pt_walk_pkg.sv
`timescale 1ns/1ps
package pt_walk_pkg;
   typedef enum logic [2:0] {
      PW_IDLE,
      PW_DIR_REQ,
      PW_DIR_WAIT,
      PW_LEAF_REQ,
      PW_LEAF_WAIT,
      PW_REFILL,
      PW_FAULT
   } pw_state_e;

   // flag bit positions inside an entry word
   localparam int unsigned FLAG_PRESENT = 0;
   localparam int unsigned FLAG_RD      = 1;
   localparam int unsigned PERM_CNT     = 4;   // rd, wr, ex, usr
   localparam int unsigned FLAG_CNT     = 1 + PERM_CNT;

   localparam logic LVL_DIR  = 1'b0;
   localparam logic LVL_LEAF = 1'b1;
endpackage

// File: rtl/pt_walk_decode.sv
`timescale 1ns/1ps
module pt_walk_decode
   import pt_walk_pkg::*;
#(
   parameter int unsigned ENTRY_W = 32,
   parameter int unsigned PFN_W   = 20
) (
   input  logic [ENTRY_W-1:0]  entry,
   output logic                present,
   output logic [PFN_W-1:0]    frame,
   output logic [PERM_CNT-1:0] perm
);
   localparam int unsigned RSVD_W = ENTRY_W - PFN_W - FLAG_CNT;

   generate
      if (PFN_W + FLAG_CNT > ENTRY_W) begin : g_bad_entry
         $error("entry word too narrow for frame and flags");
      end
   endgenerate

   assign present = entry[FLAG_PRESENT];
   assign frame   = entry[ENTRY_W-1 -: PFN_W];

   generate
      for (genvar b = 0; b < PERM_CNT; b++) begin : g_perm
         assign perm[b] = entry[FLAG_RD + b];
      end
      if (RSVD_W > 0) begin : g_rsvd
         logic rsvd_unused;
         assign rsvd_unused = ^entry[FLAG_CNT +: RSVD_W];
      end
   endgenerate
endmodule

// File: rtl/pt_walk_addr.sv
`timescale 1ns/1ps
module pt_walk_addr #(
   parameter int unsigned PA_W        = 32,
   parameter int unsigned PAGE_W      = 12,
   parameter int unsigned VPN_W       = 20,
   parameter int unsigned DIR_IDX_W   = 10,
   parameter int unsigned ENTRY_BYTES = 4
) (
   input  logic [PA_W-1:0]          root,
   input  logic [PA_W-PAGE_W-1:0]   tbl_frame,
   input  logic [VPN_W-1:0]         vpn,
   input  logic                     sel_leaf,
   output logic [PA_W-1:0]          addr
);
   localparam int unsigned TBL_IDX_W = VPN_W - DIR_IDX_W;
   localparam int unsigned SCALE_SH  = $clog2(ENTRY_BYTES);
   localparam bit          POW2      = ((1 << SCALE_SH) == ENTRY_BYTES);

   generate
      if (DIR_IDX_W >= VPN_W || PA_W <= DIR_IDX_W || PA_W <= TBL_IDX_W) begin : g_bad_idx
         $error("index field widths do not fit the address");
      end
   endgenerate

   logic [PA_W-1:0] base;
   logic [PA_W-1:0] idx_ext;

   always_comb begin
      if (sel_leaf) begin
         base    = {tbl_frame, {PAGE_W{1'b0}}};
         idx_ext = {{(PA_W-TBL_IDX_W){1'b0}}, vpn[TBL_IDX_W-1:0]};
      end else begin
         base    = root;
         idx_ext = {{(PA_W-DIR_IDX_W){1'b0}}, vpn[VPN_W-1 -: DIR_IDX_W]};
      end
   end

   generate
      if (POW2) begin : g_shift
         assign addr = base + (idx_ext << SCALE_SH);
      end else begin : g_mult
         localparam logic [PA_W-1:0] STRIDE = PA_W'(ENTRY_BYTES);
         assign addr = base + idx_ext * STRIDE;
      end
   endgenerate
endmodule

// File: rtl/pt_walk_fsm.sv
`timescale 1ns/1ps
module pt_walk_fsm
   import pt_walk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      miss_valid,
   input  logic      req_ready,
   input  logic      rsp_valid,
   input  logic      rsp_present,
   output pw_state_e state_q,
   output logic      accept,
   output logic      dir_hit,
   output logic      dir_absent,
   output logic      leaf_hit,
   output logic      leaf_absent
);
   pw_state_e state_d;

   assign accept      = (state_q == PW_IDLE) && miss_valid;
   assign dir_hit     = (state_q == PW_DIR_WAIT)  && rsp_valid &&  rsp_present;
   assign dir_absent  = (state_q == PW_DIR_WAIT)  && rsp_valid && !rsp_present;
   assign leaf_hit    = (state_q == PW_LEAF_WAIT) && rsp_valid &&  rsp_present;
   assign leaf_absent = (state_q == PW_LEAF_WAIT) && rsp_valid && !rsp_present;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PW_IDLE:      if (accept)      state_d = PW_DIR_REQ;
         PW_DIR_REQ:   if (req_ready)   state_d = PW_DIR_WAIT;
         PW_DIR_WAIT:  if (dir_hit)     state_d = PW_LEAF_REQ;
                       else if (dir_absent) state_d = PW_FAULT;
         PW_LEAF_REQ:  if (req_ready)   state_d = PW_LEAF_WAIT;
         PW_LEAF_WAIT: if (leaf_hit)    state_d = PW_REFILL;
                       else if (leaf_absent) state_d = PW_FAULT;
         PW_REFILL:    state_d = PW_IDLE;
         PW_FAULT:     state_d = PW_IDLE;
         default:      state_d = PW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PW_IDLE;
      else        state_q <= state_d;
   end

   // R3: the second read never starts without a directory response
   p_leaf_after_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PW_LEAF_REQ) && !$past(state_q == PW_LEAF_REQ)
         |-> $past(state_q == PW_DIR_WAIT) && $past(rsp_valid));
endmodule

// File: rtl/pt_walk_engine.sv
`timescale 1ns/1ps
module pt_walk_engine
   import pt_walk_pkg::*;
#(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 32,
   parameter int unsigned PAGE_W    = 12,
   parameter int unsigned DIR_IDX_W = 10,
   parameter int unsigned ENTRY_W   = 32,
   localparam int unsigned VPN_W    = VA_W - PAGE_W,
   localparam int unsigned PFN_W    = PA_W - PAGE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 miss_valid,
   output logic                 miss_ready,
   input  logic [VPN_W-1:0]     miss_vpn,
   input  logic [PA_W-1:0]      root_base,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [PA_W-1:0]      mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [ENTRY_W-1:0]   mem_rsp_data,
   output logic                 refill_valid,
   output logic [VPN_W-1:0]     refill_vpn,
   output logic [PFN_W-1:0]     refill_pfn,
   output logic [PERM_CNT-1:0]  refill_perm,
   output logic                 fault_valid,
   output logic [VPN_W-1:0]     fault_vpn,
   output logic                 fault_level
);
   localparam int unsigned ENTRY_BYTES = ENTRY_W / 8;

   generate
      if (ENTRY_W % 8 != 0 || PAGE_W >= PA_W || PAGE_W >= VA_W) begin : g_bad_cfg
         $error("unsupported walker configuration");
      end
   endgenerate

   pw_state_e              state;
   logic                   accept, dir_hit, dir_absent, leaf_hit, leaf_absent;
   logic                   ent_present;
   logic [PFN_W-1:0]       ent_frame;
   logic [PERM_CNT-1:0]    ent_perm;

   logic [VPN_W-1:0]       vpn_q;
   logic [PA_W-1:0]        root_q;
   logic [PFN_W-1:0]       tbl_frame_q;
   logic [PFN_W-1:0]       leaf_pfn_q;
   logic [PERM_CNT-1:0]    leaf_perm_q;
   logic                   flt_lvl_q;

   pt_walk_decode #(.ENTRY_W(ENTRY_W), .PFN_W(PFN_W)) u_decode (
      .entry   (mem_rsp_data),
      .present (ent_present),
      .frame   (ent_frame),
      .perm    (ent_perm)
   );

   pt_walk_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss_valid  (miss_valid),
      .req_ready   (mem_req_ready),
      .rsp_valid   (mem_rsp_valid),
      .rsp_present (ent_present),
      .state_q     (state),
      .accept      (accept),
      .dir_hit     (dir_hit),
      .dir_absent  (dir_absent),
      .leaf_hit    (leaf_hit),
      .leaf_absent (leaf_absent)
   );

   pt_walk_addr #(
      .PA_W(PA_W), .PAGE_W(PAGE_W), .VPN_W(VPN_W),
      .DIR_IDX_W(DIR_IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_addr (
      .root      (root_q),
      .tbl_frame (tbl_frame_q),
      .vpn       (vpn_q),
      .sel_leaf  (state == PW_LEAF_REQ),
      .addr      (mem_req_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpn_q       <= '0;
         root_q      <= '0;
         tbl_frame_q <= '0;
         leaf_pfn_q  <= '0;
         leaf_perm_q <= '0;
         flt_lvl_q   <= LVL_DIR;
      end else begin
         if (accept) begin
            vpn_q  <= miss_vpn;
            root_q <= root_base;
         end
         if (dir_hit)     tbl_frame_q <= ent_frame;
         if (leaf_hit) begin
            leaf_pfn_q  <= ent_frame;
            leaf_perm_q <= ent_perm;
         end
         if (dir_absent)  flt_lvl_q <= LVL_DIR;
         if (leaf_absent) flt_lvl_q <= LVL_LEAF;
      end
   end

   assign miss_ready    = (state == PW_IDLE);
   assign mem_req_valid = (state == PW_DIR_REQ) || (state == PW_LEAF_REQ);
   assign refill_valid  = (state == PW_REFILL);
   assign fault_valid   = (state == PW_FAULT);
   assign refill_vpn    = vpn_q;
   assign fault_vpn     = vpn_q;
   assign refill_pfn    = leaf_pfn_q;
   assign refill_perm   = leaf_perm_q;
   assign fault_level   = flt_lvl_q;

   // reads granted since the last accepted miss
   logic [1:0] rd_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rd_cnt_q <= '0;
      else if (miss_valid && miss_ready)       rd_cnt_q <= '0;
      else if (mem_req_valid && mem_req_ready) rd_cnt_q <= rd_cnt_q + 2'd1;
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      miss_ready |-> !mem_req_valid && !refill_valid && !fault_valid);

   p_dir_one_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid && (fault_level == LVL_DIR) |-> rd_cnt_q == 2'd1);

   p_leaf_fault_two_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid && (fault_level == LVL_LEAF) |-> rd_cnt_q == 2'd2);

   p_refill_two_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      refill_valid |-> rd_cnt_q == 2'd2);

   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid && miss_ready |=> !miss_ready);

   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(refill_valid && fault_valid));

   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid || fault_valid) |=> miss_ready && !refill_valid && !fault_valid);

   p_stray_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      miss_ready && !miss_valid && mem_rsp_valid |=> miss_ready);
endmodule

// File: tb/pt_walk_engine_tb.sv
`timescale 1ns/1ps
module pt_walk_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        miss_valid;
   logic        miss_ready;
   logic [19:0] miss_vpn;
   logic [31:0] root_base;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        refill_valid;
   logic [19:0] refill_vpn;
   logic [19:0] refill_pfn;
   logic [3:0]  refill_perm;
   logic        fault_valid;
   logic [19:0] fault_vpn;
   logic        fault_level;

   always #4 clk = ~clk;

   pt_walk_engine u_dut (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_ready(miss_ready),
      .miss_vpn(miss_vpn), .root_base(root_base),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .refill_valid(refill_valid), .refill_vpn(refill_vpn),
      .refill_pfn(refill_pfn), .refill_perm(refill_perm),
      .fault_valid(fault_valid), .fault_vpn(fault_vpn),
      .fault_level(fault_level)
   );

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory image computed from the address
   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [9:0]  i;
      logic [19:0] tb;
      if (a < 32'h0040_0000) begin
         i  = a[11:2];
         tb = 20'(32'h400 + 32'(i) * 3);
         return {tb, 11'd0, (i % 7) != 3};
      end else begin
         tb = a[31:12];
         i  = a[11:2];
         return {tb ^ 20'(32'(i) * 11), 7'd0, i[3:0] ^ tb[3:0], (i % 5) != 2};
      end
   endfunction

   // memory responder
   int          req_lat = 0, rsp_lat = 0;
   int          req_count = 0, walk_base = 0;
   logic [31:0] log_a0, log_a1;
   bit          stray = 0;
   initial begin
      int stall_n = 0, rsp_n = 0;
      bit pend = 0;
      logic [31:0] pend_a = '0;
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
      forever begin
         @(negedge clk);
         mem_req_ready = 0; mem_rsp_valid = 0;
         if (mem_req_valid) begin
            if (stall_n < req_lat) stall_n++;
            else begin
               mem_req_ready = 1;
               if (req_count == walk_base) log_a0 = mem_req_addr;
               else                        log_a1 = mem_req_addr;
               req_count++;
               pend = 1; pend_a = mem_req_addr; rsp_n = 0; stall_n = 0;
            end
         end else if (pend) begin
            if (rsp_n < rsp_lat) rsp_n++;
            else begin
               mem_rsp_valid = 1; mem_rsp_data = mem_word(pend_a); pend = 0;
            end
         end else if (stray) begin
            mem_rsp_valid = 1; mem_rsp_data = 32'hFFFF_FFFF; stray = 0;
         end
      end
   end

   task automatic do_walk(input logic [19:0] vpn, input logic [31:0] root,
                          input int rql, input int rsl, input bit poke);
      logic [9:0]  di = vpn[19:10];
      logic [9:0]  lj = vpn[9:0];
      bit          dir_ok = (di % 7) != 3;
      logic [19:0] tb = 20'(32'h400 + 32'(di) * 3);
      logic [31:0] a0 = root + 32'(di) * 4;
      logic [31:0] a1 = {tb, 12'h000} + 32'(lj) * 4;
      bit          leaf_ok = (lj % 5) != 2;
      logic [19:0] pfn = tb ^ 20'(32'(lj) * 11);
      logic [3:0]  perm = lj[3:0] ^ tb[3:0];
      int n = 0;
      bit busy_ok = 1;
      @(negedge clk);
      req_lat = rql; rsp_lat = rsl; walk_base = req_count;
      miss_vpn = vpn; root_base = root; miss_valid = 1;
      chk(miss_ready == 1'b1, "R8 ready before walk", 64'(miss_ready), 64'd1);
      @(posedge clk); #1;
      if (poke) begin
         miss_vpn = vpn ^ 20'h5A5A5; root_base = root + 32'h1000;
      end else miss_valid = 0;
      do begin
         @(negedge clk); n++;
         if (!(refill_valid || fault_valid) && miss_ready) busy_ok = 0;
      end while (!(refill_valid || fault_valid) && n < 300);
      miss_valid = 0;
      chk(n < 300, "R7 walk completes", 64'(n), 64'd0);
      chk(busy_ok, "R8 miss_ready low during walk", 64'(busy_ok), 64'd1);
      chk(!(refill_valid && fault_valid), "R9 exclusive", 64'({refill_valid, fault_valid}), 64'd0);
      chk(log_a0 == a0, "R2 directory address", 64'(log_a0), 64'(a0));
      if (!dir_ok) begin
         chk(req_count - walk_base == 1, "R4 one read", 64'(req_count - walk_base), 64'd1);
         chk(fault_valid && fault_level == 1'b0, "R4 directory fault",
             64'({fault_valid, fault_level}), 64'h2);
         chk(fault_vpn == vpn, "R4 fault vpn", 64'(fault_vpn), 64'(vpn));
      end else begin
         chk(req_count - walk_base == 2, "R3 two reads", 64'(req_count - walk_base), 64'd2);
         chk(log_a1 == a1, "R3 table address", 64'(log_a1), 64'(a1));
         if (!leaf_ok) begin
            chk(fault_valid && !refill_valid && fault_level == 1'b1, "R5 leaf fault",
                64'({refill_valid, fault_valid, fault_level}), 64'h3);
            chk(fault_vpn == vpn, "R5 fault vpn", 64'(fault_vpn), 64'(vpn));
         end else begin
            chk(refill_valid && !fault_valid, "R6 refill", 64'({refill_valid, fault_valid}), 64'h2);
            chk(refill_pfn == pfn, "R6 pfn", 64'(refill_pfn), 64'(pfn));
            chk(refill_perm == perm, "R6 perm", 64'(refill_perm), 64'(perm));
            chk(refill_vpn == vpn, "R6 vpn", 64'(refill_vpn), 64'(vpn));
         end
      end
      @(negedge clk);
      chk(miss_ready && !refill_valid && !fault_valid, "R9 single pulse then ready",
          64'({miss_ready, refill_valid, fault_valid}), 64'h4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0; miss_valid = 0; miss_vpn = '0; root_base = '0;
      repeat (3) @(negedge clk);
      chk(miss_ready && !mem_req_valid && !refill_valid && !fault_valid, "R1 in reset",
          64'({miss_ready, mem_req_valid, refill_valid, fault_valid}), 64'h8);
      rst_n = 1;
      @(negedge clk);
      chk(miss_ready && !mem_req_valid && !refill_valid && !fault_valid, "R1 after reset",
          64'({miss_ready, mem_req_valid, refill_valid, fault_valid}), 64'h8);

      // boundary pages
      do_walk(20'h00000, 32'h0001_0000, 0, 0, 0);
      do_walk(20'hFFFFF, 32'h0001_0000, 0, 0, 0);
      do_walk({10'd3, 10'd5}, 32'h0001_0000, 1, 2, 0);     // R4 absent directory
      do_walk({10'd1, 10'd2}, 32'h0002_3000, 2, 1, 0);     // R5 invalid leaf
      do_walk({10'd1023, 10'd0}, 32'h0002_3000, 3, 4, 1);  // R8 poke during walk

      // R10 stray response while idle
      @(negedge clk); stray = 1;
      @(negedge clk);
      @(negedge clk);
      chk(miss_ready && !refill_valid && !fault_valid && !mem_req_valid, "R10 stray ignored",
          64'({miss_ready, refill_valid, fault_valid, mem_req_valid}), 64'h8);
      do_walk({10'd8, 10'd9}, 32'h0001_0000, 0, 0, 0);

      // sweep of page numbers, roots and latencies
      for (int k = 0; k < 400; k++) begin
         logic [9:0] d = 10'((k * 37 + k / 7) % 1024);
         logic [9:0] l = 10'((k * 113 + 7) % 1024);
         do_walk({d, l}, (k % 2) ? 32'h0002_3000 : 32'h0001_0000,
                 k % 4, (k / 4) % 5, (k % 3) == 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule